// File: doc/BRIEF.md
# Half-Step Ratio Clock Divider

This block derives the clock for a cache RAM port from the core clock. A 3-bit ratio code selects a divide ratio of 1, 1.5, 2, 2.5, 3, 3.5 or 4, or stops the clock. Fractional ratios are built by updating state on both core clock edges. A rising-edge register and a falling-edge register are combined through a single XOR, so each period lasts a whole number of core half-periods. The high phase is as long as, or one half-period longer than, the low phase.

A ready output stands in for the settling time of a delay-locked loop. It rises after a configurable number of core cycles of running and must be seen before the RAM port is used. A code of zero stops the clock at the next period boundary and drops ready at once. While the divider runs, a different nonzero code is ignored, so the ratio can only change by going through a stop. A fault flag reports a running ratio whose output would be slower than the system bus clock. The bus divider is supplied in half-period units.

Top module: `hdiv_clock_gen`

## Requirements
- R1: During and after reset, with a ratio code of 0, `div_clk`, `lock_ready` and `ratio_fault` are low.
- R2: The ratio code maps to a period in core half-periods as follows: 1→2, 2→3, 3→7, 4→4, 5→5, 6→6, 7→8. Code 0 means stopped.
- R3: A nonzero code sampled at a rising core edge while the divider is stopped starts the output with the half-period that follows that edge. The output then repeats a period of N half-periods, where N comes from R2. It is high for the first (N+1)/2 half-periods (integer division) and low for the rest.
- R4: A code of 0 sampled while running lets the output keep its pattern until the next half-period that would begin a period. From that point the output stays low, so no pulse is cut short.
- R5: `lock_ready` rises at the LOCK_CYCLES-th rising edge, counting the edge that sampled the starting code as the first. It is low after any rising edge that samples code 0. Each new start restarts the count.
- R6: While running, a change of `ratio_code` to another nonzero value has no effect on the output pattern, `lock_ready` or `ratio_fault`.
- R7: `ratio_fault` is high after a rising edge exactly when the divider is running and not stopping, and N is greater than `bus_half`. It is updated at the same edge that starts or stops the divider.
- R8: While the divider is stopped and the code stays 0, `div_clk` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 3 | Ratio select; 0 stops the output |
| bus_half | input | BUS_W | System bus divider in core half-periods |
| div_clk | output | 1 | Divided clock |
| lock_ready | output | 1 | Settling interval complete |
| ratio_fault | output | 1 | Running ratio slower than the bus clock |

## Verification
The first half-period of output begins right after the rising edge that samples a start code. The bench therefore drives codes half a cycle ahead of that edge. It then checks the output a quarter period after every rising and every falling edge, with each sample matched to one half-period slot. `lock_ready` and `ratio_fault` change at rising edges only. Ready is expected at the LOCK_CYCLES-th sampled edge of a run and is expected low after the edge that samples a stop. The expected output during a stop follows the slot index: it tracks the running pattern until the first slot index that is a multiple of N at or after the stop edge, and is low from then on.

// File: rtl/hdiv_pkg.sv
`timescale 1ns/1ps
package hdiv_pkg;
    localparam int CODE_W = 3;
    localparam int HALF_W = 4;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [HALF_W-1:0] half_t;

    // Period of the output in core half-periods; 0 means stopped.
    function automatic half_t code_to_half(input code_t c);
        case (c)
            3'd1:    return half_t'(2);
            3'd2:    return half_t'(3);
            3'd3:    return half_t'(7);
            3'd4:    return half_t'(4);
            3'd5:    return half_t'(5);
            3'd6:    return half_t'(6);
            3'd7:    return half_t'(8);
            default: return half_t'(0);
        endcase
    endfunction

    // High for the first ceil(n/2) half-period slots of a period.
    function automatic logic slot_level(input half_t s, input half_t n);
        logic [HALF_W:0] lim;
        lim = ({1'b0, n} + {{HALF_W{1'b0}}, 1'b1}) >> 1;
        return ({1'b0, s} < lim);
    endfunction
endpackage

// File: rtl/hdiv_ctrl.sv
`timescale 1ns/1ps
module hdiv_ctrl
    import hdiv_pkg::*;
#(
    parameter int BUS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  code_t            code_i,
    input  logic [BUS_W-1:0] bus_half_i,
    output logic             lvl_a_o,
    output logic             lvl_b_o,
    output logic             run_d_o,
    output code_t            act_o,
    output logic             fault_o
);
    typedef struct packed {
        code_t act;
        half_t h;
        logic  pend;
        logic  fault;
    } ctrl_t;

    ctrl_t st_d, st_q;
    half_t n2, hn, hh;
    logic  pend, run_d;

    always_comb begin
        st_d    = st_q;
        lvl_a_o = 1'b0;
        lvl_b_o = 1'b0;
        n2      = code_to_half(st_q.act);
        pend    = 1'b0;
        hn      = '0;
        hh      = '0;
        if (st_q.act == '0) begin
            if (code_i != '0) begin
                n2        = code_to_half(code_i);
                st_d.act  = code_i;
                st_d.pend = 1'b0;
                lvl_a_o   = slot_level(half_t'(0), n2);
                lvl_b_o   = slot_level(half_t'(1), n2);
                st_d.h    = (n2 == half_t'(2)) ? half_t'(0) : half_t'(2);
            end
        end else begin
            pend = st_q.pend | (code_i == '0);
            if (pend && (st_q.h == '0 || st_q.h == n2 - half_t'(1))) begin
                st_d.act  = '0;
                st_d.h    = '0;
                st_d.pend = 1'b0;
            end else begin
                hn        = (st_q.h + half_t'(1) >= n2) ? half_t'(0) : st_q.h + half_t'(1);
                hh        = st_q.h + half_t'(2);
                lvl_a_o   = slot_level(st_q.h, n2);
                lvl_b_o   = slot_level(hn, n2);
                st_d.h    = (hh >= n2) ? hh - n2 : hh;
                st_d.pend = pend;
            end
        end
        run_d      = (st_d.act != '0) && !st_d.pend;
        st_d.fault = run_d && (int'(code_to_half(st_d.act)) > int'(bus_half_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_d_o = run_d;
    assign act_o   = st_q.act;
    assign fault_o = st_q.fault;

    p_hold_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act != '0) |=> (st_q.act == $past(st_q.act) || st_q.act == '0));

    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act != '0) |-> (st_q.h < code_to_half(st_q.act)));
endmodule

// File: rtl/hdiv_lock.sv
`timescale 1ns/1ps
module hdiv_lock #(
    parameter int LOCK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic ready_o
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ready;
    } lock_t;

    lock_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (!run_i) begin
            lk_d.cnt   = '0;
            lk_d.ready = 1'b0;
        end else begin
            if (lk_q.cnt != CNT_W'(LOCK_CYCLES)) lk_d.cnt = lk_q.cnt + 1'b1;
            lk_d.ready = (lk_d.cnt == CNT_W'(LOCK_CYCLES));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign ready_o = lk_q.ready;

    p_ready_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i) |=> !ready_o);
endmodule

// File: rtl/hdiv_edge_out.sv
`timescale 1ns/1ps
module hdiv_edge_out (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_a_i,
    input  logic lvl_b_i,
    output logic clk_o
);
    typedef struct packed {
        logic p;
        logic bh;
    } pos_t;

    pos_t pos_d, pos_q;
    logic neg_d, neg_q;

    always_comb begin
        pos_d.p  = lvl_a_i ^ neg_q;
        pos_d.bh = lvl_b_i;
        neg_d    = pos_q.bh ^ pos_q.p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= neg_d;
    end

    assign clk_o = pos_q.p ^ neg_q;
endmodule

// File: rtl/hdiv_clock_gen.sv
`timescale 1ns/1ps
module hdiv_clock_gen
    import hdiv_pkg::*;
#(
    parameter int LOCK_CYCLES = 16,
    parameter int BUS_W       = 5
) (
    input  logic             clk_core,
    input  logic             rst_n,
    input  logic [2:0]       ratio_code,
    input  logic [BUS_W-1:0] bus_half,
    output logic             div_clk,
    output logic             lock_ready,
    output logic             ratio_fault
);
    logic  lvl_a, lvl_b, run_d;
    code_t act;

    hdiv_ctrl #(.BUS_W(BUS_W)) u_ctrl (
        .clk        (clk_core),
        .rst_n      (rst_n),
        .code_i     (ratio_code),
        .bus_half_i (bus_half),
        .lvl_a_o    (lvl_a),
        .lvl_b_o    (lvl_b),
        .run_d_o    (run_d),
        .act_o      (act),
        .fault_o    (ratio_fault)
    );

    hdiv_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk     (clk_core),
        .rst_n   (rst_n),
        .run_i   (run_d),
        .ready_o (lock_ready)
    );

    hdiv_edge_out u_out (
        .clk     (clk_core),
        .rst_n   (rst_n),
        .lvl_a_i (lvl_a),
        .lvl_b_i (lvl_b),
        .clk_o   (div_clk)
    );

    p_lock_clear_r5: assert property (@(posedge clk_core) disable iff (!rst_n)
        (ratio_code == 3'd0) |=> !lock_ready);

    p_idle_low_r8: assert property (@(posedge clk_core) disable iff (!rst_n)
        (act == '0 && $past(act) == '0) |-> !div_clk);

    p_fault_gated_r7: assert property (@(posedge clk_core) disable iff (!rst_n)
        ratio_fault |-> (act != '0));
endmodule

// File: tb/hdiv_clock_gen_tb_top.sv
`timescale 1ns/1ps
module hdiv_clock_gen_tb_top;
    localparam int LOCK  = 16;
    localparam int BUS_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       ratio_code = 3'd0;
    logic [BUS_W-1:0] bus_half = '0;
    logic             div_clk, lock_ready, ratio_fault;
    int               checks = 0;
    int               errors = 0;
    bit               done = 1'b0;

    always #2.5 clk = ~clk;

    hdiv_clock_gen #(.LOCK_CYCLES(LOCK), .BUS_W(BUS_W)) dut_i (
        .clk_core    (clk),
        .rst_n       (rst_n),
        .ratio_code  (ratio_code),
        .bus_half    (bus_half),
        .div_clk     (div_clk),
        .lock_ready  (lock_ready),
        .ratio_fault (ratio_fault)
    );

    function automatic int exp_half(input logic [2:0] c);
        case (c)
            3'd1: return 2;  3'd2: return 3;  3'd3: return 7;  3'd4: return 4;
            3'd5: return 5;  3'd6: return 6;  3'd7: return 8;  default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        #1;
        chk("R1", "clk in reset", div_clk, 1'b0);
        chk("R1", "ready in reset", lock_ready, 1'b0);
        chk("R1", "fault in reset", ratio_fault, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1.25;
        chk("R1", "clk after reset", div_clk, 1'b0);
        chk("R1", "ready after reset", lock_ready, 1'b0);
        chk("R1", "fault after reset", ratio_fault, 1'b0);
    endtask

    // R8: idle stays low
    task automatic t_idle(input int cyc);
        for (int j = 0; j < cyc; j++) begin
            @(posedge clk); #1.25; chk("R8", "idle high phase", div_clk, 1'b0);
            @(negedge clk); #1.25; chk("R8", "idle low phase", div_clk, 1'b0);
        end
    endtask

    // R2 R3 R5 R7 run, optional R6 swap, then R4 stop
    task automatic t_run(input logic [2:0] code, input int bus, input int cyc,
                         input logic [2:0] swap_code, input int swap_at);
        int n2, hi, s;
        bit stopped;
        logic fexp;
        n2 = exp_half(code);
        hi = (n2 + 1) / 2;
        fexp = (n2 > bus);
        @(negedge clk);
        bus_half = BUS_W'(bus);
        ratio_code = code;
        for (int j = 0; j < cyc; j++) begin
            @(posedge clk); #1.25;
            chk((swap_at >= 0 && j > swap_at) ? "R6" : "R3", $sformatf("code %0d slot %0d", code, 2*j),
                div_clk, logic'(((2*j) % n2) < hi));
            chk((swap_at >= 0 && j > swap_at) ? "R6" : "R5", $sformatf("ready cycle %0d", j),
                lock_ready, logic'(j >= LOCK - 1));
            chk("R7", $sformatf("fault code %0d bus %0d", code, bus), ratio_fault, fexp);
            if (j == swap_at) ratio_code = swap_code;
            @(negedge clk); #1.25;
            chk("R2", $sformatf("code %0d slot %0d", code, 2*j+1), div_clk, logic'(((2*j+1) % n2) < hi));
        end
        ratio_code = 3'd0;
        s = 2 * cyc;
        stopped = 1'b0;
        for (int j = 0; j < 12; j++) begin
            @(posedge clk); #1.25;
            if (s % n2 == 0) stopped = 1'b1;
            chk("R4", $sformatf("stop slot %0d", s), div_clk, stopped ? 1'b0 : logic'((s % n2) < hi));
            chk("R5", "ready after stop", lock_ready, 1'b0);
            chk("R7", "fault after stop", ratio_fault, 1'b0);
            s++;
            @(negedge clk); #1.25;
            if (s % n2 == 0) stopped = 1'b1;
            chk("R4", $sformatf("stop slot %0d", s), div_clk, stopped ? 1'b0 : logic'((s % n2) < hi));
            s++;
        end
    endtask

    initial begin
        t_reset();
        t_idle(4);
        t_run(3'd1, 4, 20, 3'd0, -1);
        t_run(3'd2, 4, 20, 3'd0, -1);
        t_run(3'd3, 4, 19, 3'd0, -1);
        t_run(3'd4, 4, 21, 3'd0, -1);
        t_run(3'd5, 4, 20, 3'd0, -1);
        t_run(3'd6, 6, 18, 3'd0, -1);
        t_run(3'd7, 8, 20, 3'd0, -1);
        t_run(3'd3, 16, 22, 3'd0, -1);
        t_run(3'd1, 4, 24, 3'd7, 5);
        t_run(3'd5, 4, 23, 3'd2, 3);
        t_idle(6);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule